// File: doc/BRIEF.md
# I2C Channel-Select Multiplexer Controller

This block is the digital core of an I2C target that steers one upstream bus onto one of several downstream channels. It oversamples the shared SCL and SDA lines with the system clock and picks out START and STOP conditions. It answers to one fixed 7-bit address and keeps a single 8-bit control register. A host write sets that register, and a host read returns it. A decoder turns the register into one-hot channel enables, which drive the external pass switches.

The register has two fields. Bit 3 turns switching on, and the bits below it select the channel by number. Because of this encoding, at most one channel can be connected at any time. The asynchronous reset returns the block to its defaults, and so does a separate active-low bus-recovery reset. The default selects channel 0. The block drives SDA only through an open-drain pull-down request. The bus wiring combines this request with the line off chip.

Top module: `i2c_chan_mux`

## Requirements
- R1: When control bit 3 is 0, all channel enables are low, whatever the other bits hold.
- R2: When control bit 3 is 1, exactly one enable is high: the enable whose index equals control bits 2..0 (binary, 000 selects enable 0, 111 selects enable 7).
- R3: Bits 7..4 of a written byte have no effect on the enables, but the register stores them and a read returns them unchanged.
- R4: After the asynchronous reset the register holds 0x08, only enable 0 is high, and SDA is released.
- R5: Holding bus_rst_ni low for one clock, even in the middle of a transfer, restores the register to 0x08 and returns the transfer logic to idle with SDA released.
- R6: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START, the first byte is taken MSB first as a 7-bit address followed by a direction bit (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low during the ninth clock.
- R7: A byte whose address does not match is not acknowledged. The data bytes that follow it are also not acknowledged, and they leave the register unchanged.
- R8: Each data byte in a write transfer is acknowledged. Its value reaches the enables after the falling SCL edge that ends its eighth bit, not before that edge. A later byte in the same transfer replaces the earlier one.
- R9: A read transfer shifts out the register MSB first, one bit per SCL clock. If the host acknowledges, the register is sent again. If the host does not acknowledge, SDA is released until the next START.
- R10: A STOP or a repeated START inside a byte abandons that byte and leaves the register unchanged. The transfer that follows is handled normally.
- R11: SDA is released while idle, after a STOP, and after a read the host did not acknowledge. The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| bus_rst_ni | input | 1 | Synchronous active-low bus-recovery reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain request) |
| chan_en_o | output | 8 | One-hot downstream channel enables |

## Verification
The bench builds the block with the target address set to 0x5A and keeps the default 3-bit channel index and two-stage synchronizers. With this build, all eight channels and every low-nibble code, both with enable set and with enable clear, can be swept through real bus transfers. The upper nibble changes from step to step, so every write also checks the stored bits that must not affect the enables. The bus is run at four system clocks per quarter bit. This rate puts the update at the acknowledge inside a narrow window the bench can observe, between the eighth bit's high phase and the ninth clock.

// File: rtl/i2c_mux_pkg.sv
package i2c_mux_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_mux_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_q;
  logic [NLINES-1:0] line_d;

  assign line_in = {scl_i, sda_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], line_in[l]};
    end
    assign line_q[l] = chain_q[STAGES-1];
  end

  // previous synchronized sample, idle-high after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_d <= '1;
    else         line_d <= line_q;
  end

  logic scl_s, sda_s, scl_p, sda_p;
  assign scl_s = line_q[1];
  assign sda_s = line_q[0];
  assign scl_p = line_d[1];
  assign sda_p = line_d[0];

  always_comb begin
    evt_o.scl      = scl_s;
    evt_o.sda      = sda_s;
    evt_o.scl_rise = scl_s & ~scl_p;
    evt_o.scl_fall = ~scl_s & scl_p;
    evt_o.start    = scl_s & scl_p & sda_p & ~sda_s;
    evt_o.stop     = scl_s & scl_p & ~sda_p & sda_s;
  end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_mux_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h70,
  parameter int         REG_W       = 8,
  parameter logic [REG_W-1:0] RST_VAL = REG_W'(8'h08)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_ni,
  input  bus_evt_t         evt_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             sda_pull_o
);

  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] LAST_IN  = CNT_W'(REG_W);
  localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(REG_W - 1);

  tgt_state_e       state_q;
  logic [REG_W-1:0] shift_q;
  logic [REG_W-1:0] tx_q;
  logic [REG_W-1:0] ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rw_q;
  logic             nack_q;
  logic             pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      tx_q    <= '0;
      ctrl_q  <= RST_VAL;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (!srst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= RST_VAL;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (evt_i.stop) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else if (evt_i.start) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (evt_i.scl_rise) begin
            shift_q <= {shift_q[REG_W-2:0], evt_i.sda};
            cnt_q   <= cnt_q + 1'b1;
          end else if (evt_i.scl_fall && cnt_q == LAST_IN) begin
            if (shift_q[7:1] == TARGET_ADDR) begin
              state_q <= ST_ADDR_ACK;
              rw_q    <= shift_q[0];
              pull_q  <= 1'b1;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt_i.scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RD;
              tx_q    <= ctrl_q;
              pull_q  <= ~ctrl_q[REG_W-1];
            end else begin
              state_q <= ST_WR;
              pull_q  <= 1'b0;
            end
          end
        end
        ST_WR: begin
          if (evt_i.scl_rise) begin
            shift_q <= {shift_q[REG_W-2:0], evt_i.sda};
            cnt_q   <= cnt_q + 1'b1;
          end else if (evt_i.scl_fall && cnt_q == LAST_IN) begin
            ctrl_q  <= shift_q;  // selection lands at the acknowledge
            pull_q  <= 1'b1;
            state_q <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (evt_i.scl_fall) begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (evt_i.scl_fall) begin
            if (cnt_q == LAST_OUT) begin
              pull_q  <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              cnt_q  <= cnt_q + 1'b1;
              tx_q   <= {tx_q[REG_W-2:0], 1'b0};
              pull_q <= ~tx_q[REG_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (evt_i.scl_rise) begin
            nack_q <= evt_i.sda;
          end else if (evt_i.scl_fall) begin
            if (nack_q) begin
              state_q <= ST_SKIP;
            end else begin
              state_q <= ST_RD;
              cnt_q   <= '0;
              tx_q    <= ctrl_q;
              pull_q  <= ~ctrl_q[REG_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign sda_pull_o = pull_q;

  // R10
  stop_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_ni && evt_i.stop) |=> (state_q == ST_IDLE && !pull_q));

  // R11
  pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_q != $past(pull_q)) |-> (!$past(evt_i.scl) || !$past(srst_ni)));

  // R8
  ctrl_at_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |-> (state_q == ST_WR_ACK || !$past(srst_ni)));

  // R5
  bus_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_ni |=> (ctrl_q == RST_VAL && state_q == ST_IDLE && !pull_q));

  // R7
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !pull_q);

endmodule

// File: rtl/chan_decode.sv
module chan_decode #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W:0]        sel_i,
  output logic [(1<<IDX_W)-1:0] en_o
);

  localparam int NUM_CH = 1 << IDX_W;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign en_o[g] = sel_i[IDX_W] && (sel_i[IDX_W-1:0] == IDX_W'(g));
  end

endmodule

// File: rtl/i2c_chan_mux.sv
module i2c_chan_mux
  import i2c_mux_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h70,
  parameter int         CH_IDX_W    = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_pull_o,
  output logic [(1<<CH_IDX_W)-1:0] chan_en_o
);

  localparam int REG_W  = 8;
  localparam int EN_BIT = CH_IDX_W;
  localparam logic [REG_W-1:0] RST_VAL = REG_W'(1 << EN_BIT);

  bus_evt_t         evt;
  logic [REG_W-1:0] ctrl;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  i2c_target_fsm #(
    .TARGET_ADDR(TARGET_ADDR),
    .REG_W      (REG_W),
    .RST_VAL    (RST_VAL)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_ni   (bus_rst_ni),
    .evt_i     (evt),
    .ctrl_o    (ctrl),
    .sda_pull_o(sda_pull_o)
  );

  chan_decode #(
    .IDX_W(CH_IDX_W)
  ) u_dec (
    .sel_i(ctrl[EN_BIT:0]),
    .en_o (chan_en_o)
  );

  // R2
  one_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_en_o));

endmodule

// File: tb/i2c_chan_mux_bench.sv
module i2c_chan_mux_bench;

  localparam logic [6:0] ADDR = 7'h5A;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst_n = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_pull;
  logic [7:0] chan;
  logic sda_line;

  assign sda_line = sda_h & ~sda_pull;

  always #4 clk = ~clk;

  i2c_chan_mux #(
    .TARGET_ADDR(ADDR)
  ) u_i2c_chan_mux (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bus_rst_ni(bus_rst_n),
    .scl_i     (scl_h),
    .sda_i     (sda_line),
    .sda_pull_o(sda_pull),
    .chan_en_o (chan)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_chan(input logic [7:0] v);
    return v[3] ? 8'(1 << v[2:0]) : 8'h00;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_h = 1'b1; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b0; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_h = 1'b0; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    sda_h = b; wq();
    scl_h = 1'b1; wq(); wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_h = 1'b1; wq();
    scl_h = 1'b1; wq();
    b = sda_line; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic byte_w(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic byte_r(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(nack);
  endtask

  task automatic write_sel(input logic [7:0] v, input string req);
    logic a;
    i2c_start();
    byte_w({ADDR, 1'b0}, a);
    chk({req, " addr ack"}, a, 1'b1);
    byte_w(v, a);
    chk({req, " data ack"}, a, 1'b1);
    i2c_stop();
  endtask

  task automatic read_sel(output logic [7:0] v);
    logic a;
    i2c_start();
    byte_w({ADDR, 1'b1}, a);
    chk("R6 read addr ack", a, 1'b1);
    byte_r(v, 1'b1);
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic a;
    logic b;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 reset state
    chk("R4 chan after reset", chan, 8'h01);
    chk("R4 sda released", sda_pull, 1'b0);
    read_sel(rv);
    chk("R4 R9 read default", rv, 8'h08);
    chk("R11 released after nack read", sda_pull, 1'b0);

    // R1 R2 R3 sweep over every low-nibble code with changing upper nibble
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = {4'(i * 7 + 3), 4'(i)};
      write_sel(v, "R6 R8");
      chk(v[3] ? "R2 selected channel" : "R1 disabled", chan, exp_chan(v));
      read_sel(rv);
      chk("R3 R9 readback", rv, v);
      chk("R11 released after stop", sda_pull, 1'b0);
    end

    // R7 wrong address
    write_sel(8'h0B, "R7 setup");
    i2c_start();
    byte_w({ADDR ^ 7'h01, 1'b0}, a);
    chk("R7 no ack on foreign address", a, 1'b0);
    byte_w(8'h0E, a);
    chk("R7 no ack on data", a, 1'b0);
    i2c_stop();
    chk("R7 chan unchanged", chan, exp_chan(8'h0B));

    // R8 update timing and multi-byte write
    i2c_start();
    byte_w({ADDR, 1'b0}, a);
    chk("R8 addr ack", a, 1'b1);
    for (int i = 7; i >= 1; i--) bit_out(8'h0E >> i);
    sda_h = 1'b0; wq();
    scl_h = 1'b1; wq();
    chk("R8 old value before ack", chan, exp_chan(8'h0B));
    wq();
    scl_h = 1'b0; wq();
    chk("R8 new value at ack", chan, exp_chan(8'h0E));
    bit_in(b);
    chk("R8 data ack", b, 1'b0);
    byte_w(8'h95, a);
    chk("R8 second byte ack", a, 1'b1);
    chk("R8 second byte applied", chan, exp_chan(8'h95));
    i2c_stop();

    // R10 stop inside a byte
    i2c_start();
    byte_w({ADDR, 1'b0}, a);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    i2c_stop();
    chk("R10 chan after stop abort", chan, exp_chan(8'h95));
    read_sel(rv);
    chk("R10 reg after stop abort", rv, 8'h95);

    // R10 repeated start inside a byte
    i2c_start();
    byte_w({ADDR, 1'b0}, a);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    i2c_start();
    byte_w({ADDR, 1'b1}, a);
    chk("R10 ack after repeated start", a, 1'b1);
    byte_r(rv, 1'b0);
    chk("R10 R9 read after repeated start", rv, 8'h95);
    byte_r(rv, 1'b1);
    chk("R9 second read byte after host ack", rv, 8'h95);
    i2c_stop();
    write_sel(8'h0F, "R10 follow-up");
    chk("R10 follow-up write", chan, 8'h80);

    // R5 bus reset mid transfer
    i2c_start();
    byte_w({ADDR, 1'b0}, a);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_rst_n = 1'b0;
    @(negedge clk);
    bus_rst_n = 1'b1;
    @(negedge clk);
    chk("R5 chan after bus reset", chan, 8'h01);
    chk("R5 sda released", sda_pull, 1'b0);
    i2c_stop();
    read_sel(rv);
    chk("R5 reg after bus reset", rv, 8'h08);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule